// File: doc/BRIEF.md
# Dual-Mode Shared Bus Ownership Arbiter

This block decides which master drives a shared external bus: the on-chip processor side or one outside master such as a DMA engine. It runs in one of two modes. In the two-wire mode the outside master raises a request, and the block answers with an acknowledge once the processor side has stopped using the bus. The decision is made inside the block, so no arbiter is needed on the board.

In the three-wire mode the block becomes one participant in an off-chip arbitration scheme. It raises a request when the processor side needs the bus and watches a grant from the external arbiter. A shared busy line marks the bus as occupied. Arbitration runs during the current owner's transfer, so the bus changes owner one clock after the previous owner drops busy.

The processor side signals that it needs the bus and marks the final beat of each transfer or burst. It may drive the bus only while the bus-owned output is high. The selected mode is sampled only at an idle boundary. Data paths and pad drivers are outside the block.

Top module: `dual_mode_bus_arbiter`

## Requirements
- R1: During and directly after reset the block is in two-wire mode with the processor side owning the bus: `core_owns`=1, `ext_ack`=0, `arb_req`=0, `bus_busy_out`=0, whatever `mode_sel` is.
- R2: Two-wire mode (`mode_sel`=0): an `ext_req` that arrives while no processor transfer is in progress drops `core_owns` in the same cycle. `ext_ack` rises in the following cycle.
- R3: Two-wire mode: an `ext_req` that arrives during a processor transfer leaves `core_owns` high through the beat flagged by `core_xfer_last`. `ext_ack` rises only in the cycle after that beat.
- R4: Once asserted, `ext_ack` stays high for as long as `ext_req` is high, whatever `core_need` does. It drops in the cycle after `ext_req` is sampled low, and `core_owns` returns in that same cycle.
- R5: Two-wire mode: when `core_need` and `ext_req` are both high at an idle boundary, the outside master wins. `core_owns` stays low and `ext_ack` follows.
- R6: Three-wire mode (`mode_sel`=1): while the processor side does not own the bus, `arb_req` equals `core_need`. `core_owns` stays low until the bus is taken.
- R7: Three-wire mode: the bus is taken only on a clock edge where `arb_grant`=1 and `bus_busy_in`=0. A grant while busy is high, or busy low without a grant, takes nothing.
- R8: Three-wire mode: `bus_busy_out` and `core_owns` rise in the cycle after the take. They stay high through the final beat, even if the grant is removed, and fall in the cycle after the beat flagged by `core_xfer_last`.
- R9: A change of `mode_sel` takes effect only at an edge where no processor transfer is in progress or starting and no acknowledge is being held. Entering three-wire mode leaves the processor side as a non-owner. Entering two-wire mode hands it the bus one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = two-wire request/acknowledge, 1 = three-wire request/grant/busy |
| core_need | input | 1 | Processor side wants the bus |
| core_xfer_last | input | 1 | Final beat of the processor's current transfer or burst |
| ext_req | input | 1 | Outside master request (two-wire mode) |
| arb_grant | input | 1 | Grant from the external arbiter (three-wire mode) |
| bus_busy_in | input | 1 | Sampled shared busy line |
| core_owns | output | 1 | Processor side may drive the bus this cycle |
| ext_ack | output | 1 | Acknowledge to the outside master (two-wire mode) |
| arb_req | output | 1 | Request to the external arbiter (three-wire mode) |
| bus_busy_out | output | 1 | Drive the shared busy line |

## Verification
The two-wire handshake is exercised with four patterns. A request with the processor side idle shows that release is immediate. A request raised during a multi-beat burst shows that release waits for the final beat. A request that coincides with a processor need shows the priority. A long-held request while the processor keeps asking shows that the acknowledge holds. The three-wire side is tried with several combinations: grant alone, busy alone, grant with busy, and grant with busy low, which separates a legal take from a premature one. A multi-beat burst with the grant removed mid-way, and a single-beat transfer, check when busy is released. Mode switches are requested both during a burst and when idle, to show that they are deferred.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_CORE  = 2'd0,   // processor side holds the bus
        ST_YIELD = 2'd1,   // two-wire: outside master holds the bus, ack high
        ST_OFF   = 2'd2    // three-wire: not the owner, may request
    } own_st_e;

    typedef struct packed {
        own_st_e st;
        logic    three_wire;
    } arb_regs_t;

endpackage

// File: rtl/arb_xfer_track.sv
module arb_xfer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic core_owns,
    input  logic core_need,
    input  logic core_xfer_last,
    output logic xfer_q,
    output logic beat_last
);

    logic xfer_d;

    always_comb begin
        beat_last = core_owns & core_xfer_last & (xfer_q | core_need);
        xfer_d    = xfer_q;
        if (beat_last) begin
            xfer_d = 1'b0;
        end else if (core_owns && core_need) begin
            xfer_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_q <= 1'b0;
        end else begin
            xfer_q <= xfer_d;
        end
    end

endmodule

// File: rtl/arb_own_fsm.sv
module arb_own_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic core_need,
    input  logic ext_req,
    input  logic arb_grant,
    input  logic bus_busy_in,
    input  logic xfer_q,
    input  logic beat_last,
    output logic core_owns,
    output logic ext_ack,
    output logic arb_req,
    output logic bus_busy_out
);

    arb_regs_t r_q, r_d;
    logic      idle_pt;
    logic      rel_two, rel_three, take_three;

    always_comb begin
        core_owns    = (r_q.st == ST_CORE) &&
                       !(!r_q.three_wire && ext_req && !xfer_q);
        ext_ack      = (r_q.st == ST_YIELD);
        bus_busy_out = (r_q.st == ST_CORE) && r_q.three_wire;
        arb_req      = r_q.three_wire && core_need && (r_q.st == ST_OFF);

        idle_pt    = !xfer_q && !(core_owns && core_need);
        rel_two    = ext_req && (!xfer_q || beat_last);
        rel_three  = beat_last || (!xfer_q && !core_need);
        take_three = core_need && arb_grant && !bus_busy_in;

        r_d = r_q;
        if ((mode_sel != r_q.three_wire) && idle_pt && (r_q.st != ST_YIELD)) begin
            r_d.three_wire = mode_sel;
            r_d.st         = mode_sel ? ST_OFF : ST_CORE;
        end else begin
            unique case (r_q.st)
                ST_CORE: begin
                    if (!r_q.three_wire && rel_two) begin
                        r_d.st = ST_YIELD;
                    end else if (r_q.three_wire && rel_three) begin
                        r_d.st = ST_OFF;
                    end
                end
                ST_YIELD: begin
                    if (!ext_req) begin
                        r_d.st = ST_CORE;
                    end
                end
                ST_OFF: begin
                    if (r_q.three_wire && take_three) begin
                        r_d.st = ST_CORE;
                    end
                end
                default: r_d.st = ST_CORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st         <= ST_CORE;
            r_q.three_wire <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/dual_mode_bus_arbiter.sv
module dual_mode_bus_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic core_need,
    input  logic core_xfer_last,
    input  logic ext_req,
    input  logic arb_grant,
    input  logic bus_busy_in,
    output logic core_owns,
    output logic ext_ack,
    output logic arb_req,
    output logic bus_busy_out
);

    logic xfer_q;
    logic beat_last;

    arb_xfer_track u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .core_owns      (core_owns),
        .core_need      (core_need),
        .core_xfer_last (core_xfer_last),
        .xfer_q         (xfer_q),
        .beat_last      (beat_last)
    );

    arb_own_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .core_need    (core_need),
        .ext_req      (ext_req),
        .arb_grant    (arb_grant),
        .bus_busy_in  (bus_busy_in),
        .xfer_q       (xfer_q),
        .beat_last    (beat_last),
        .core_owns    (core_owns),
        .ext_ack      (ext_ack),
        .arb_req      (arb_req),
        .bus_busy_out (bus_busy_out)
    );

endmodule

// File: rtl/dual_mode_bus_arbiter_chk.sv
module dual_mode_bus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic core_need,
    input logic core_xfer_last,
    input logic ext_req,
    input logic arb_grant,
    input logic bus_busy_in,
    input logic core_owns,
    input logic ext_ack,
    input logic bus_busy_out
);

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_ack && core_owns)); // R2

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ack) |-> $past(ext_req)); // R2

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ack && ext_req) |=> ext_ack); // R4

    AST_NO_MIDBURST_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_owns && core_need && !core_xfer_last) |=> core_owns); // R3

    AST_TAKE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy_out) |-> $past(arb_grant && !bus_busy_in)); // R7

    AST_BUSY_THROUGH_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy_out && core_need && !core_xfer_last) |=> bus_busy_out); // R8

endmodule

bind dual_mode_bus_arbiter dual_mode_bus_arbiter_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_need      (core_need),
    .core_xfer_last (core_xfer_last),
    .ext_req        (ext_req),
    .arb_grant      (arb_grant),
    .bus_busy_in    (bus_busy_in),
    .core_owns      (core_owns),
    .ext_ack        (ext_ack),
    .bus_busy_out   (bus_busy_out)
);

// File: tb/dual_mode_bus_arbiter_test.sv
module dual_mode_bus_arbiter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0, core_need = 1'b0, core_xfer_last = 1'b0;
    logic ext_req = 1'b0, arb_grant = 1'b0, bus_busy_in = 1'b0;
    logic core_owns, ext_ack, arb_req, bus_busy_out;

    typedef struct {
        logic  own;
        logic  ack;
        logic  req;
        logic  busy;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #5 clk = ~clk;

    dual_mode_bus_arbiter uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_sel       (mode_sel),
        .core_need      (core_need),
        .core_xfer_last (core_xfer_last),
        .ext_req        (ext_req),
        .arb_grant      (arb_grant),
        .bus_busy_in    (bus_busy_in),
        .core_owns      (core_owns),
        .ext_ack        (ext_ack),
        .arb_req        (arb_req),
        .bus_busy_out   (bus_busy_out)
    );

    // driver: one call per clock cycle, inputs applied at the falling edge
    task automatic cyc(input logic rs, input logic md, input logic nd,
                       input logic ls, input logic er, input logic gn,
                       input logic bi, input logic e_own, input logic e_ack,
                       input logic e_req, input logic e_busy, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rs; mode_sel = md; core_need = nd; core_xfer_last = ls;
        ext_req = er; arb_grant = gn; bus_busy_in = bi;
        e.own = e_own; e.ack = e_ack; e.req = e_req; e.busy = e_busy; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: samples 1 ns before the rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if ({core_owns, ext_ack, arb_req, bus_busy_out} !==
                    {e.own, e.ack, e.req, e.busy}) begin
                    n_fails++;
                    $display("FAIL %s: own/ack/req/busy actual %b%b%b%b expected %b%b%b%b",
                             e.tag, core_owns, ext_ack, arb_req, bus_busy_out,
                             e.own, e.ack, e.req, e.busy);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        //   rs md nd ls er gn bi   own ack req busy
        cyc(0, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R1 in reset");
        cyc(0, 1, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R1 mode ignored in reset");
        cyc(1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R1 after reset");
        // idle request
        cyc(1, 0, 0, 0, 1, 0, 0,   0, 0, 0, 0, "R2 release same cycle");
        cyc(1, 0, 0, 0, 1, 0, 0,   0, 1, 0, 0, "R2 ack next cycle");
        cyc(1, 0, 1, 0, 1, 0, 0,   0, 1, 0, 0, "R4 ack held with core need");
        cyc(1, 0, 0, 0, 0, 0, 0,   0, 1, 0, 0, "R4 ack until req sampled low");
        cyc(1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R4 ownership returns");
        // request during a burst
        cyc(1, 0, 1, 0, 0, 0, 0,   1, 0, 0, 0, "R3 burst start");
        cyc(1, 0, 1, 0, 1, 0, 0,   1, 0, 0, 0, "R3 req mid burst");
        cyc(1, 0, 1, 0, 1, 0, 0,   1, 0, 0, 0, "R3 still owner");
        cyc(1, 0, 1, 1, 1, 0, 0,   1, 0, 0, 0, "R3 final beat");
        cyc(1, 0, 0, 0, 1, 0, 0,   0, 1, 0, 0, "R3 ack after final beat");
        cyc(1, 0, 0, 0, 0, 0, 0,   0, 1, 0, 0, "R4 ack drop pending");
        cyc(1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R4 back to core");
        // simultaneous need and request
        cyc(1, 0, 1, 0, 1, 0, 0,   0, 0, 0, 0, "R5 outside master wins");
        cyc(1, 0, 1, 0, 1, 0, 0,   0, 1, 0, 0, "R5 ack to outside master");
        cyc(1, 0, 1, 0, 0, 0, 0,   0, 1, 0, 0, "R5 ack drop pending");
        cyc(1, 0, 1, 0, 0, 0, 0,   1, 0, 0, 0, "R5 core resumes");
        // mode switch deferred by a transfer
        cyc(1, 1, 1, 0, 0, 0, 0,   1, 0, 0, 0, "R9 switch held mid transfer");
        cyc(1, 1, 1, 1, 0, 0, 0,   1, 0, 0, 0, "R9 switch held on final beat");
        cyc(1, 1, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R9 idle edge applies switch");
        cyc(1, 1, 0, 0, 0, 0, 0,   0, 0, 0, 0, "R9 three-wire non-owner");
        // three-wire arbitration
        cyc(1, 1, 1, 0, 0, 0, 0,   0, 0, 1, 0, "R6 request follows need");
        cyc(1, 1, 1, 0, 0, 1, 1,   0, 0, 1, 0, "R7 grant while busy");
        cyc(1, 1, 1, 0, 0, 0, 0,   0, 0, 1, 0, "R7 busy low without grant");
        cyc(1, 1, 1, 0, 0, 1, 0,   0, 0, 1, 0, "R7 legal take edge");
        cyc(1, 1, 1, 0, 0, 1, 1,   1, 0, 0, 1, "R8 busy after take");
        cyc(1, 1, 1, 0, 0, 0, 1,   1, 0, 0, 1, "R8 grant removed mid burst");
        cyc(1, 1, 1, 1, 0, 0, 1,   1, 0, 0, 1, "R8 final beat");
        cyc(1, 1, 0, 0, 0, 0, 0,   0, 0, 0, 0, "R8 busy released");
        cyc(1, 1, 1, 0, 0, 1, 0,   0, 0, 1, 0, "R7 take for single beat");
        cyc(1, 1, 1, 1, 0, 1, 1,   1, 0, 0, 1, "R8 single beat");
        cyc(1, 1, 0, 0, 0, 0, 0,   0, 0, 0, 0, "R8 single beat released");
        // back to two-wire
        cyc(1, 0, 0, 0, 0, 0, 0,   0, 0, 0, 0, "R9 switch to two-wire");
        cyc(1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R9 core owns in two-wire");
        cyc(1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, "R1 steady two-wire");
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule